// File: doc/BRIEF.md
# Register modification recorder

This block keeps a running log of the general-register side effects (auto-increment and auto-decrement steps) taken by the instruction currently in flight. When a memory-management abort stops that instruction part-way, the abort handler reads the log and reverses each step before the instruction is retried. The address-mode logic reports every register step as it happens. Each report gives a 3-bit register number and a signed 5-bit change amount. The block packs up to two such reports into one 16-bit status word.

An instruction-start strobe empties the log. Reports then fill the low record first and the high record second. For a two-operand instruction, this puts the source register step below the destination register step. The abort logic raises a freeze input. While freeze is high, the word cannot change, so software reads exactly the state at the moment of the fault, including the step of the operand whose access aborted.

Top module: `regmod_recorder`

## Requirements
- R1: After reset, `status_o` reads 0x0000.
- R2: Each 8-bit record holds the register number in bits 2:0 and the change amount in bits 7:3, stored unchanged as 5-bit two's complement: +2 is 00010, -2 is 11110 and -1 is 11111.
- R3: The first report after an instruction start is written to bits 7:0, and bits 15:8 stay zero. This gives a single-record word, as for an abort in the source field.
- R4: The second report after an instruction start is written to bits 15:8, and bits 7:0 keep the first report.
- R5: A third or later report within the same instruction leaves the word unchanged.
- R6: An instruction start with freeze low and no report in the same cycle clears the word to 0x0000 on the next clock edge.
- R7: An instruction start and a report in the same cycle, with freeze low, leave the report in bits 7:0 and zero in bits 15:8.
- R8: While freeze is high, reports and instruction starts leave the word unchanged. After freeze drops, the next report goes into the next free record.
- R9: A cycle with no report and no instruction start leaves the word unchanged. This covers a plain register-deferred operand, which makes no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_start_i | input | 1 | Instruction boundary strobe, empties the log |
| upd_valid_i | input | 1 | Register step report strobe |
| upd_reg_i | input | 3 | Number of the stepped register |
| upd_delta_i | input | 5 | Signed step amount, two's complement |
| freeze_i | input | 1 | Abort hold, keeps the word stable |
| status_o | output | 16 | Two packed register/step records |

## Verification
Report sequences of length one, two and three check the fill order. They show whether the block puts the first report low and the second high, and whether it drops any report after the second. The step amounts +2, -2 and -1 on several register numbers check the field layout and show any swapping of the number and amount fields. A start on its own, and a start together with a report, show the difference between clearing the log and clearing before recording. A freeze window with reports and starts applied inside it, followed by a report after release, shows both the hold and the fill position that is kept during the hold.

// File: rtl/rmr_pkg.sv
package rmr_pkg;
  localparam int unsigned REG_W_DEF   = 3;
  localparam int unsigned DELTA_W_DEF = 5;
  localparam int unsigned SLOTS_DEF   = 2;
endpackage

// File: rtl/rmr_fill_ctrl.sv
module rmr_fill_ctrl #(
  parameter int unsigned SLOTS = rmr_pkg::SLOTS_DEF,
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             freeze_i,
  output logic             clr_o,
  output logic [SLOTS-1:0] wr_en_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             cnt_en;

  always_comb begin
    clr_o   = start_i && !freeze_i;
    base    = start_i ? '0 : cnt_q;
    wr_en_o = '0;
    cnt_d   = base;
    for (int i = 0; i < SLOTS; i++) begin
      if (!freeze_i && valid_i && (base == CNT_W'(i))) begin
        wr_en_o[i] = 1'b1;
        cnt_d      = CNT_W'(i + 1);
      end
    end
    cnt_en = !freeze_i && (start_i || valid_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_one_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o));
  p_full_drops_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(SLOTS) && !start_i) |-> (wr_en_o == '0));
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(SLOTS));
  p_frozen_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(cnt_q));
endmodule

// File: rtl/rmr_slot.sv
module rmr_slot #(
  parameter int unsigned REG_W   = rmr_pkg::REG_W_DEF,
  parameter int unsigned DELTA_W = rmr_pkg::DELTA_W_DEF,
  localparam int unsigned REC_W  = REG_W + DELTA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   reg_i,
  input  logic [DELTA_W-1:0] delta_i,
  output logic [REC_W-1:0]   rec_o
);
  logic [REC_W-1:0] rec_q, rec_d;
  logic             rec_en;

  always_comb begin
    rec_en = clr_i || wr_i;
    rec_d  = wr_i ? {delta_i, reg_i} : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rec_q <= '0;
    else if (rec_en) rec_q <= rec_d;
  end

  assign rec_o = rec_q;

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wr_i) |=> $stable(rec_o));
endmodule

// File: rtl/regmod_recorder.sv
module regmod_recorder #(
  parameter int unsigned REG_W   = rmr_pkg::REG_W_DEF,
  parameter int unsigned DELTA_W = rmr_pkg::DELTA_W_DEF,
  parameter int unsigned SLOTS   = rmr_pkg::SLOTS_DEF,
  localparam int unsigned REC_W  = REG_W + DELTA_W,
  localparam int unsigned WORD_W = SLOTS * REC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               insn_start_i,
  input  logic               upd_valid_i,
  input  logic [REG_W-1:0]   upd_reg_i,
  input  logic [DELTA_W-1:0] upd_delta_i,
  input  logic               freeze_i,
  output logic [WORD_W-1:0]  status_o
);
  logic             clr;
  logic [SLOTS-1:0] wr_en;

  rmr_fill_ctrl #(.SLOTS(SLOTS)) u_fill (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (insn_start_i),
    .valid_i  (upd_valid_i),
    .freeze_i (freeze_i),
    .clr_o    (clr),
    .wr_en_o  (wr_en)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    rmr_slot #(.REG_W(REG_W), .DELTA_W(DELTA_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr),
      .wr_i    (wr_en[s]),
      .reg_i   (upd_reg_i),
      .delta_i (upd_delta_i),
      .rec_o   (status_o[s*REC_W +: REC_W])
    );
  end

  p_freeze_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(status_o));
  p_start_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_start_i && !freeze_i && !upd_valid_i) |=> (status_o == '0));
  p_start_record_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_start_i && !freeze_i && upd_valid_i) |=>
      (status_o[REC_W-1:0] == {$past(upd_delta_i), $past(upd_reg_i)}) &&
      (status_o[WORD_W-1:REC_W] == '0));
  p_reset_zero_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (status_o == '0));
endmodule

// File: tb/regmod_recorder_test.sv
module regmod_recorder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  rnum = '0;
  logic [4:0]  delta = '0;
  logic        frz = 1'b0;
  logic [15:0] status;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  regmod_recorder uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .insn_start_i (start),
    .upd_valid_i  (valid),
    .upd_reg_i    (rnum),
    .upd_delta_i  (delta),
    .freeze_i     (frz),
    .status_o     (status)
  );

  task automatic check(input string req, input logic [15:0] exp);
    n_chk++;
    if (status !== exp) begin
      n_bad++;
      $display("FAIL %s: status=%h expected=%h", req, status, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic s, input logic v, input logic [2:0] r,
                      input logic [4:0] d, input logic f);
    @(negedge clk);
    start = s; valid = v; rnum = r; delta = d; frz = f;
    @(posedge clk);
    #1;
    start = 1'b0; valid = 1'b0; frz = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", 16'h0000);
  endtask

  task automatic t_single();
    step(1, 0, 0, 0, 0);
    step(0, 1, 3'd2, 5'b00010, 0);
    check("R3", 16'h0012);
    step(1, 0, 0, 0, 0);
    step(0, 1, 3'd2, 5'b11111, 0);
    check("R2", 16'h00FA);
  endtask

  task automatic t_pair();
    step(1, 0, 0, 0, 0);
    step(0, 1, 3'd3, 5'b11110, 0);
    check("R2", 16'h00F3);
    step(0, 1, 3'd2, 5'b00010, 0);
    check("R4", 16'h12F3);
    step(0, 1, 3'd5, 5'b00001, 0);
    check("R5", 16'h12F3);
    step(0, 1, 3'd7, 5'b11110, 0);
    check("R5", 16'h12F3);
    step(0, 0, 3'd1, 5'b00010, 0);
    step(0, 0, 0, 0, 0);
    check("R9", 16'h12F3);
  endtask

  task automatic t_start();
    step(1, 0, 0, 0, 0);
    check("R6", 16'h0000);
    step(0, 1, 3'd4, 5'b00010, 0);
    step(0, 1, 3'd6, 5'b11110, 0);
    check("R4", 16'hF614);
    step(1, 1, 3'd4, 5'b11110, 0);
    check("R7", 16'h00F4);
  endtask

  task automatic t_freeze();
    step(1, 1, 3'd2, 5'b00010, 0);
    check("R7", 16'h0012);
    step(0, 1, 3'd5, 5'b11110, 1);
    check("R8", 16'h0012);
    step(1, 0, 0, 0, 1);
    check("R8", 16'h0012);
    step(1, 1, 3'd1, 5'b11111, 1);
    check("R8", 16'h0012);
    step(0, 1, 3'd5, 5'b00010, 0);
    check("R8", 16'h1512);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_single();
    t_pair();
    t_start();
    t_freeze();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule